// File: doc/BRIEF.md
# Synchronous PWM Channel Update Controller

This block decides when a group of PWM channels that run from one shared time base move their staged period and duty values into the registers that drive the waveform. Each channel has a staging buffer and an active register. Channels flagged as grouped change only on a common commit event, so all of them change on the same clock edge. Ungrouped channels take their staged values at every boundary of the shared period.

A protected configuration register sets three things: the policy that fires the commit, the length of the update interval, and the source of the write-ready flag and the transfer request. Under the manual policy, software arms an unlock bit and the commit happens at the next period boundary. Under the automatic policy, the commit happens each time the interval counter runs out. The DMA-fed policy commits in the same way, and its duty values arrive through a request/acknowledge handshake with an external transfer engine.

Top module: `sync_pwm_upd_ctrl`

## Requirements
- R1: A configuration write (`wr_en`) updates the `cfg_*` readback outputs on the next clock only when `wp_sw` and `wp_hw` are both low. Otherwise the write is ignored.
- R2: Bit i of `cfg_sync` set to 1 makes channel i a grouped channel. An ungrouped channel copies its staged period and duty into `act_period`/`act_duty` at every `period_end` pulse. `buf_we` writes the staging buffer of channel `buf_ch`. Buffer contents never show on the active outputs before a copy.
- R3: When `cfg_mode` = 0 (manual) and `unlock_pend` is high, a `period_end` pulse commits all grouped channels and clears `unlock_pend`. A pulse on `unlock_set` sets `unlock_pend`. If `unlock_set` arrives in the same cycle as a commit, `unlock_pend` stays set.
- R4: When `cfg_mode` = 1 (automatic), grouped channels commit on a `period_end` pulse that finds the interval counter at zero. This pulse is the elapsed event.
- R5: The interval counter resets to 0. On each `period_end` it reloads `cfg_upr` if it is zero and otherwise decrements. Elapsed events therefore repeat every `cfg_upr`+1 periods.
- R6: When `cfg_mode` = 2 (DMA-fed), grouped channels commit as in R4. `dma_ack` writes `dma_duty` into the duty buffer of channel `dma_ch`. `dma_ack` leaves the buffers untouched in every other mode.
- R7: When `cfg_mode` = 3 (reserved), grouped channels never commit and `unlock_pend` is not cleared.
- R8: `cfg_req` controls `wrdy`: 0 means never set, 1 or 2 means set on the elapsed event, and 3 means set when `cmp_match[cfg_sel]` is high. `status_rd`, `buf_we` or `dma_ack` clear `wrdy`. A set in the same cycle wins over a clear.
- R9: `dma_req` sets only when `cfg_mode` = 2, either with `cfg_req` = 2 on the elapsed event or with `cfg_req` = 3 on the selected comparison match. It stays high until `dma_ack`. A set in the same cycle wins over an acknowledge.
- R10: Active registers change only on a clock whose cycle carried `period_end`. All channels that commit on that pulse change on the same edge.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wp_sw | input | 1 | Software write-protect |
| wp_hw | input | 1 | Hardware write-protect |
| wr_sync | input | NCH | Grouped-channel mask to write |
| wr_mode | input | 2 | Update policy to write |
| wr_req | input | 2 | Request source to write |
| wr_sel | input | SELW | Comparison select to write |
| wr_upr | input | UPW | Update interval to write |
| cfg_sync | output | NCH | Grouped-channel mask |
| cfg_mode | output | 2 | Update policy |
| cfg_req | output | 2 | Request source |
| cfg_sel | output | SELW | Comparison select |
| cfg_upr | output | UPW | Update interval reload |
| unlock_set | input | 1 | Arms the manual commit |
| period_end | input | 1 | Shared period boundary pulse |
| buf_we | input | 1 | Staging buffer write |
| buf_ch | input | CHW | Channel for buffer write |
| buf_period | input | PW | Staged period value |
| buf_duty | input | DW | Staged duty value |
| dma_ack | input | 1 | Transfer acknowledge / duty write |
| dma_ch | input | CHW | Channel for transferred duty |
| dma_duty | input | DW | Transferred duty value |
| cmp_match | input | NCMP | Comparison match inputs |
| status_rd | input | 1 | Status read, clears wrdy |
| act_period | output | NCH*PW | Active periods, channel 0 in low bits |
| act_duty | output | NCH*DW | Active duties, channel 0 in low bits |
| unlock_pend | output | 1 | Manual commit armed |
| wrdy | output | 1 | Write-ready flag |
| dma_req | output | 1 | Transfer request |

## Verification
A wrong interval count shows as a commit on the wrong period boundary. It becomes visible at the active outputs within one clock of the boundary on which the correct and incorrect counts differ, and also on `wrdy` in period request mode. A stale or misrouted staging buffer stays hidden until the next copy, so the reference model checks the active outputs on every cycle across many boundaries. Faults in the unlock and request flags appear on `unlock_pend`, `wrdy` and `dma_req` one clock after the event that should have changed them.

// File: rtl/sync_upd_pkg.sv
package sync_upd_pkg;
   typedef enum logic [1:0] {
      UPD_MANUAL = 2'd0,
      UPD_AUTO   = 2'd1,
      UPD_DMA    = 2'd2,
      UPD_RSVD   = 2'd3
   } upd_mode_e;

   typedef enum logic [1:0] {
      REQ_OFF        = 2'd0,
      REQ_PERIOD     = 2'd1,
      REQ_PERIOD_DMA = 2'd2,
      REQ_COMPARE    = 2'd3
   } req_mode_e;
endpackage

// File: rtl/sync_upd_timer.sv
module sync_upd_timer #(
   parameter int UPW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           period_end,
   input  logic [UPW-1:0] reload,
   output logic           elapsed
);
   logic [UPW-1:0] cnt_q;

   assign elapsed = period_end && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (period_end) begin
         if (cnt_q == '0) cnt_q <= reload;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/sync_upd_reqgen.sv
module sync_upd_reqgen
   import sync_upd_pkg::*;
#(
   parameter int NCMP = 8,
   localparam int SELW = (NCMP > 1) ? $clog2(NCMP) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  upd_mode_e       mode,
   input  req_mode_e       reqm,
   input  logic [SELW-1:0] sel,
   input  logic            elapsed,
   input  logic [NCMP-1:0] cmp_match,
   input  logic            wrdy_clr,
   input  logic            dma_ack,
   output logic            wrdy,
   output logic            dma_req
);
   logic hit;
   logic wrdy_set;
   logic dma_set;

   generate
      if (NCMP == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel;
         assign hit = cmp_match[0];
      end else begin : g_multi
         assign hit = cmp_match[sel];
      end
   endgenerate

   always_comb begin
      unique case (reqm)
         REQ_OFF:        wrdy_set = 1'b0;
         REQ_PERIOD:     wrdy_set = elapsed;
         REQ_PERIOD_DMA: wrdy_set = elapsed;
         default:        wrdy_set = hit;
      endcase
      dma_set = (mode == UPD_DMA) &&
                (((reqm == REQ_PERIOD_DMA) && elapsed) ||
                 ((reqm == REQ_COMPARE) && hit));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wrdy    <= 1'b0;
         dma_req <= 1'b0;
      end else begin
         if (wrdy_set)      wrdy <= 1'b1;
         else if (wrdy_clr) wrdy <= 1'b0;
         if (dma_set)       dma_req <= 1'b1;
         else if (dma_ack)  dma_req <= 1'b0;
      end
   end
endmodule

// File: rtl/sync_upd_chan.sv
module sync_upd_chan #(
   parameter int PW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_period,
   input  logic [DW-1:0] wr_duty,
   input  logic          dma_en,
   input  logic [DW-1:0] dma_duty,
   input  logic          apply,
   output logic [PW-1:0] act_period,
   output logic [DW-1:0] act_duty
);
   logic [PW-1:0] stg_period;
   logic [DW-1:0] stg_duty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_period <= '0;
         stg_duty   <= '0;
         act_period <= '0;
         act_duty   <= '0;
      end else begin
         if (wr_en) begin
            stg_period <= wr_period;
            stg_duty   <= wr_duty;
         end
         if (dma_en) stg_duty <= dma_duty;
         if (apply) begin
            act_period <= stg_period;
            act_duty   <= stg_duty;
         end
      end
   end
endmodule

// File: rtl/sync_pwm_upd_ctrl.sv
module sync_pwm_upd_ctrl
   import sync_upd_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int PW   = 16,
   parameter int DW   = 16,
   parameter int UPW  = 4,
   parameter int NCMP = 8,
   localparam int SELW = (NCMP > 1) ? $clog2(NCMP) : 1,
   localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wp_sw,
   input  logic              wp_hw,
   input  logic [NCH-1:0]    wr_sync,
   input  logic [1:0]        wr_mode,
   input  logic [1:0]        wr_req,
   input  logic [SELW-1:0]   wr_sel,
   input  logic [UPW-1:0]    wr_upr,
   output logic [NCH-1:0]    cfg_sync,
   output logic [1:0]        cfg_mode,
   output logic [1:0]        cfg_req,
   output logic [SELW-1:0]   cfg_sel,
   output logic [UPW-1:0]    cfg_upr,
   input  logic              unlock_set,
   input  logic              period_end,
   input  logic              buf_we,
   input  logic [CHW-1:0]    buf_ch,
   input  logic [PW-1:0]     buf_period,
   input  logic [DW-1:0]     buf_duty,
   input  logic              dma_ack,
   input  logic [CHW-1:0]    dma_ch,
   input  logic [DW-1:0]     dma_duty,
   input  logic [NCMP-1:0]   cmp_match,
   input  logic              status_rd,
   output logic [NCH*PW-1:0] act_period,
   output logic [NCH*DW-1:0] act_duty,
   output logic              unlock_pend,
   output logic              wrdy,
   output logic              dma_req
);
   generate
      if (NCH < 1 || NCH > 4) begin : g_bad_nch
         $error("sync_pwm_upd_ctrl: NCH must be 1 to 4");
      end
      if (UPW < 1 || PW < 1 || DW < 1) begin : g_bad_width
         $error("sync_pwm_upd_ctrl: widths must be positive");
      end
      if (NCMP < 1 || NCMP > 8 || (NCMP & (NCMP - 1)) != 0) begin : g_bad_ncmp
         $error("sync_pwm_upd_ctrl: NCMP must be a power of two up to 8");
      end
   endgenerate

   upd_mode_e mode_q;
   req_mode_e reqm_q;
   logic      cfg_ok;
   logic      elapsed;
   logic      commit;
   logic      wrdy_clr;

   assign cfg_ok = wr_en && !wp_sw && !wp_hw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_sync <= '0;
         mode_q   <= UPD_MANUAL;
         reqm_q   <= REQ_OFF;
         cfg_sel  <= '0;
         cfg_upr  <= '0;
      end else if (cfg_ok) begin
         cfg_sync <= wr_sync;
         mode_q   <= upd_mode_e'(wr_mode);
         reqm_q   <= req_mode_e'(wr_req);
         cfg_sel  <= wr_sel;
         cfg_upr  <= wr_upr;
      end
   end

   assign cfg_mode = mode_q;
   assign cfg_req  = reqm_q;

   sync_upd_timer #(.UPW(UPW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .period_end (period_end),
      .reload     (cfg_upr),
      .elapsed    (elapsed)
   );

   always_comb begin
      unique case (mode_q)
         UPD_MANUAL: commit = period_end && unlock_pend;
         UPD_AUTO:   commit = elapsed;
         UPD_DMA:    commit = elapsed;
         default:    commit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              unlock_pend <= 1'b0;
      else if (unlock_set)                     unlock_pend <= 1'b1;
      else if (commit && mode_q == UPD_MANUAL) unlock_pend <= 1'b0;
   end

   assign wrdy_clr = status_rd || buf_we || dma_ack;

   sync_upd_reqgen #(.NCMP(NCMP)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_q),
      .reqm      (reqm_q),
      .sel       (cfg_sel),
      .elapsed   (elapsed),
      .cmp_match (cmp_match),
      .wrdy_clr  (wrdy_clr),
      .dma_ack   (dma_ack),
      .wrdy      (wrdy),
      .dma_req   (dma_req)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic ch_wr;
         logic ch_dma;
         logic ch_apply;
         assign ch_wr    = buf_we && (buf_ch == CHW'(i));
         assign ch_dma   = dma_ack && (mode_q == UPD_DMA) && (dma_ch == CHW'(i));
         assign ch_apply = period_end && (!cfg_sync[i] || commit);

         sync_upd_chan #(.PW(PW), .DW(DW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (ch_wr),
            .wr_period  (buf_period),
            .wr_duty    (buf_duty),
            .dma_en     (ch_dma),
            .dma_duty   (dma_duty),
            .apply      (ch_apply),
            .act_period (act_period[i*PW +: PW]),
            .act_duty   (act_duty[i*DW +: DW])
         );
      end
   endgenerate
endmodule

// File: rtl/sync_upd_ctrl_chk.sv
module sync_upd_ctrl_chk #(
   parameter int NCH  = 4,
   parameter int PW   = 16,
   parameter int DW   = 16,
   parameter int UPW  = 4,
   parameter int SELW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wp_sw,
   input logic              wp_hw,
   input logic [NCH-1:0]    cfg_sync,
   input logic [1:0]        cfg_mode,
   input logic [1:0]        cfg_req,
   input logic [SELW-1:0]   cfg_sel,
   input logic [UPW-1:0]    cfg_upr,
   input logic              unlock_set,
   input logic              period_end,
   input logic              dma_ack,
   input logic [NCH*PW-1:0] act_period,
   input logic [NCH*DW-1:0] act_duty,
   input logic              unlock_pend,
   input logic              wrdy,
   input logic              dma_req
);
   // R1
   cfg_wp_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wp_sw || wp_hw)) |=> ($stable(cfg_sync) && $stable(cfg_mode) &&
      $stable(cfg_req) && $stable(cfg_sel) && $stable(cfg_upr)));

   // R10
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end |=> ($stable(act_period) && $stable(act_duty)));

   // R7
   rsvd_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd3 && (&cfg_sync)) |=> ($stable(act_period) && $stable(act_duty)));

   // R7
   rsvd_unlock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd3 && unlock_pend) |=> unlock_pend);

   // R3
   unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd0 && unlock_pend && period_end && !unlock_set) |=> !unlock_pend);

   // R9
   dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && !dma_ack) |=> dma_req);

   // R9
   dma_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != 2'd2 && !dma_req) |=> !dma_req);

   // R8
   wrdy_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req == 2'd0 && !wrdy) |=> !wrdy);
endmodule

bind sync_pwm_upd_ctrl sync_upd_ctrl_chk #(
   .NCH(NCH), .PW(PW), .DW(DW), .UPW(UPW), .SELW(SELW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wp_sw       (wp_sw),
   .wp_hw       (wp_hw),
   .cfg_sync    (cfg_sync),
   .cfg_mode    (cfg_mode),
   .cfg_req     (cfg_req),
   .cfg_sel     (cfg_sel),
   .cfg_upr     (cfg_upr),
   .unlock_set  (unlock_set),
   .period_end  (period_end),
   .dma_ack     (dma_ack),
   .act_period  (act_period),
   .act_duty    (act_duty),
   .unlock_pend (unlock_pend),
   .wrdy        (wrdy),
   .dma_req     (dma_req)
);

// File: tb/sync_pwm_upd_ctrl_test.sv
`timescale 1ns/1ps
module sync_pwm_upd_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 0, wp_sw = 0, wp_hw = 0;
   logic [3:0]  wr_sync = 0;
   logic [1:0]  wr_mode = 0, wr_req = 0;
   logic [2:0]  wr_sel = 0;
   logic [3:0]  wr_upr = 0;
   logic [3:0]  cfg_sync;
   logic [1:0]  cfg_mode, cfg_req;
   logic [2:0]  cfg_sel;
   logic [3:0]  cfg_upr;
   logic        unlock_set = 0, period_end = 0, buf_we = 0, dma_ack = 0, status_rd = 0;
   logic [1:0]  buf_ch = 0, dma_ch = 0;
   logic [15:0] buf_period = 0, buf_duty = 0, dma_duty = 0;
   logic [7:0]  cmp_match = 0;
   logic [63:0] act_period, act_duty;
   logic        unlock_pend, wrdy, dma_req;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sync_pwm_upd_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wp_sw(wp_sw), .wp_hw(wp_hw),
      .wr_sync(wr_sync), .wr_mode(wr_mode), .wr_req(wr_req), .wr_sel(wr_sel),
      .wr_upr(wr_upr), .cfg_sync(cfg_sync), .cfg_mode(cfg_mode), .cfg_req(cfg_req),
      .cfg_sel(cfg_sel), .cfg_upr(cfg_upr), .unlock_set(unlock_set),
      .period_end(period_end), .buf_we(buf_we), .buf_ch(buf_ch),
      .buf_period(buf_period), .buf_duty(buf_duty), .dma_ack(dma_ack),
      .dma_ch(dma_ch), .dma_duty(dma_duty), .cmp_match(cmp_match),
      .status_rd(status_rd), .act_period(act_period), .act_duty(act_duty),
      .unlock_pend(unlock_pend), .wrdy(wrdy), .dma_req(dma_req)
   );

   // Behavioural reference model
   int m_bp[4], m_bd[4], m_ap[4], m_ad[4];
   int m_sync, m_mode, m_req, m_sel, m_upr, m_cnt;
   bit m_unl, m_wrdy, m_dma;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            m_bp[i] = 0; m_bd[i] = 0; m_ap[i] = 0; m_ad[i] = 0;
         end
         m_sync = 0; m_mode = 0; m_req = 0; m_sel = 0; m_upr = 0; m_cnt = 0;
         m_unl = 0; m_wrdy = 0; m_dma = 0;
      end else begin
         bit elapsed, commit, hit, wset, dset;
         elapsed = period_end && (m_cnt == 0);
         hit = cmp_match[m_sel];
         if (m_mode == 0)      commit = period_end && m_unl;
         else if (m_mode == 3) commit = 0;
         else                  commit = elapsed;
         for (int i = 0; i < 4; i++) begin
            if (period_end && (((m_sync >> i) & 1) == 0 || commit)) begin
               m_ap[i] = m_bp[i]; m_ad[i] = m_bd[i];
            end
         end
         if (buf_we) begin
            m_bp[buf_ch] = buf_period; m_bd[buf_ch] = buf_duty;
         end
         if (dma_ack && m_mode == 2) m_bd[dma_ch] = dma_duty;
         if (period_end) m_cnt = (m_cnt == 0) ? m_upr : m_cnt - 1;
         if (unlock_set) m_unl = 1;
         else if (commit && m_mode == 0) m_unl = 0;
         wset = (m_req == 1 || m_req == 2) ? elapsed : (m_req == 3 ? hit : 0);
         dset = (m_mode == 2) && ((m_req == 2 && elapsed) || (m_req == 3 && hit));
         if (wset) m_wrdy = 1;
         else if (status_rd || buf_we || dma_ack) m_wrdy = 0;
         if (dset) m_dma = 1;
         else if (dma_ack) m_dma = 0;
         if (wr_en && !wp_sw && !wp_hw) begin
            m_sync = wr_sync; m_mode = wr_mode; m_req = wr_req;
            m_sel = wr_sel; m_upr = wr_upr;
         end
      end
   end

   task automatic chk(string tag, logic [63:0] got, logic [63:0] exp, string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic logic [63:0] pack(input int v[4]);
      logic [63:0] r;
      for (int i = 0; i < 4; i++) r[i*16 +: 16] = v[i][15:0];
      return r;
   endfunction

   task automatic compare_all();
      string mt;
      case (m_mode)
         0: mt = "R3 R2 R10";
         1: mt = "R4 R5 R2 R10";
         2: mt = "R6 R5 R2 R10";
         default: mt = "R7 R2 R10";
      endcase
      chk("R1", {cfg_sync, cfg_mode, cfg_req, cfg_sel, cfg_upr},
          {m_sync[3:0], m_mode[1:0], m_req[1:0], m_sel[2:0], m_upr[3:0]}, "config");
      chk(mt, act_period, pack(m_ap), "act_period");
      chk(mt, act_duty, pack(m_ad), "act_duty");
      chk("R3", unlock_pend, m_unl, "unlock_pend");
      chk("R8", wrdy, m_wrdy, "wrdy");
      chk("R9", dma_req, m_dma, "dma_req");
   endtask

   // One phase: protected write of a configuration, then random traffic
   task automatic phase(int mode, int req, int sel, int upr, int sync, int n, bit wild);
      @(negedge clk);
      compare_all();
      wr_en = 1; wp_sw = 0; wp_hw = 0;
      wr_mode = mode[1:0]; wr_req = req[1:0]; wr_sel = sel[2:0];
      wr_upr = upr[3:0]; wr_sync = sync[3:0];
      period_end = 0; buf_we = 0; dma_ack = 0; status_rd = 0; unlock_set = 0;
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         compare_all();
         wr_en = wild ? ($urandom % 3 == 0) : 1'b0;
         wp_sw = wild ? ($urandom % 2 == 0) : 1'b0;
         wp_hw = wild ? ($urandom % 2 == 0) : 1'b0;
         wr_mode = 2'($urandom); wr_req = 2'($urandom); wr_sel = 3'($urandom);
         wr_upr = 4'($urandom % 4); wr_sync = 4'($urandom);
         period_end = ($urandom % 4 == 0);
         buf_we = ($urandom % 4 == 0);
         buf_ch = 2'($urandom); buf_period = 16'($urandom); buf_duty = 16'($urandom);
         dma_ack = dma_req ? ($urandom % 2 == 0) : ($urandom % 16 == 0);
         dma_ch = 2'($urandom); dma_duty = 16'($urandom);
         status_rd = ($urandom % 8 == 0);
         unlock_set = ($urandom % 12 == 0);
         cmp_match = 8'($urandom);
      end
      wr_en = 0; wp_sw = 0; wp_hw = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11", {cfg_sync, cfg_mode, cfg_req, cfg_sel, cfg_upr}, 64'd0, "config at reset");
      chk("R11", act_period, 64'd0, "act_period at reset");
      chk("R11", act_duty, 64'd0, "act_duty at reset");
      chk("R11", {unlock_pend, wrdy, dma_req}, 64'd0, "flags at reset");
      rst_n = 1;
      phase(1, 1, 0, 2, 4'b1111, 300, 0);   // automatic, all grouped
      phase(1, 2, 0, 0, 4'b0101, 200, 0);   // mixed grouped / independent
      phase(0, 0, 0, 3, 4'b1111, 300, 0);   // manual with unlock
      phase(2, 2, 0, 1, 4'b1111, 300, 0);   // DMA-fed, period requests
      phase(2, 3, 5, 2, 4'b0111, 300, 0);   // DMA-fed, comparison requests
      phase(3, 1, 0, 0, 4'b1111, 200, 0);   // reserved mode
      phase(1, 3, 2, 3, 4'b1010, 200, 0);   // comparison flag, no DMA
      phase(0, 2, 0, 1, 4'b1100, 500, 1);   // protected writes under traffic (R1)
      @(negedge clk);
      compare_all();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule